// File: doc/BRIEF.md
# Two-Street Crossing Controller with Pedestrian Phase

This block sequences the right-of-way at a crossing of two streets, called here north-south and east-west. It drives one enable output per street. Time is divided into one-minute phases, each measured by an internal cycle counter whose length is a parameter. With nobody waiting, the green phase goes to each street in turn. A pedestrian push-button input can be pressed at any moment. The press is remembered and served at the next minute boundary by a dedicated phase in which both outputs are high. After that phase, normal alternation continues.

A press never shortens the phase in progress. Any number of presses before service give a single pedestrian phase. A press that comes in while the pedestrian phase is running, or in the cycle it starts, is kept and served after one regular phase. After a pedestrian phase, the right-of-way goes to the street that did not hold it just before that phase. A synchronous reset puts the controller in the east-west phase, with the timer at zero and no request pending.

Top module: `xing_ctrl`

## Requirements
- R1: With no request pending, the outputs are ns_go=0, ew_go=1 for one minute, then ns_go=1, ew_go=0 for one minute, and this repeats.
- R2: Every phase lasts exactly TICKS_PER_MIN clock cycles, and the outputs change only on a minute boundary.
- R3: A press registered on a clock edge before a minute boundary does not change the outputs in the phase that is running. If that phase is a regular one, the boundary that ends it starts the pedestrian phase. With no request pending, a regular phase is never followed by a pedestrian phase.
- R4: During the pedestrian phase, ns_go=1 and ew_go=1 for one full minute.
- R5: Several presses before the request is served produce exactly one pedestrian phase.
- R6: After a pedestrian phase, the next phase is given to the street that did not hold the phase just before the pedestrian phase.
- R7: A press made during the pedestrian phase, or on the edge that ends a phase, is not served at that edge. It is kept and served at the following boundary that ends a regular phase. A pedestrian phase is never followed directly by another pedestrian phase.
- R8: Synchronous reset (rst=1 at a rising edge) gives ns_go=0 and ew_go=1 after that edge. It restarts the minute timer and discards any pending request.
- R9: Outside reset, ns_go and ew_go are never both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| walk_btn | input | 1 | Pedestrian push-button, sampled on every rising edge |
| ns_go | output | 1 | Registered enable for the north-south street |
| ew_go | output | 1 | Registered enable for the east-west street |

## Verification
Four rules are checked by the assertions on every cycle:
- The phase holds between minute boundaries.
- A pedestrian phase is never followed by a second one.
- A regular phase with no pending request never leads to a pedestrian phase.
- The two outputs are never both low.

Three behaviours need the bench's scenarios, which compare every cycle against an arithmetic model of the requirements:
- A request is served at the correct boundary, including a press on the boundary edge itself and a press during the pedestrian phase.
- A burst of presses collapses into one pedestrian phase.
- After a pedestrian phase, the turn goes to the correct street.

// File: rtl/xing_pkg.sv
package xing_pkg;

  // Phase codes; bit 0 names the street for the two regular phases.
  typedef enum logic [1:0] {
    PH_EW   = 2'b00,
    PH_NS   = 2'b01,
    PH_WALK = 2'b10
  } phase_e;

  // Street identifiers used to remember who had the turn before a walk.
  localparam logic ST_EW = 1'b0;
  localparam logic ST_NS = 1'b1;

  function automatic logic ns_lamp(input phase_e ph);
    return (ph == PH_NS) || (ph == PH_WALK);
  endfunction

  function automatic logic ew_lamp(input phase_e ph);
    return (ph == PH_EW) || (ph == PH_WALK);
  endfunction

  function automatic phase_e street_phase(input logic st);
    return st ? PH_NS : PH_EW;
  endfunction

endpackage

// File: rtl/xing_tick.sv
// Minute timer: counts clock cycles and flags the last cycle of each minute.
module xing_tick #(
  parameter int unsigned TICKS_PER_MIN = 6000000
) (
  input  logic clk,
  input  logic rst,
  output logic min_end
);

  localparam int unsigned CW = (TICKS_PER_MIN > 2) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MIN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign min_end = (cnt_q == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    min_end |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/xing_req.sv
// Pedestrian request holder: set by any press, cleared when a walk is taken.
module xing_req (
  input  logic clk,
  input  logic rst,
  input  logic press,
  input  logic take,
  output logic pending
);

  logic req_q;

  // A press on the edge that takes the request re-arms it (R7).
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= (req_q && !take) || press;
    end
  end

  assign pending = req_q;

  AST_REQ_ONE_WALK: assert property (@(posedge clk) disable iff (rst)
    take |=> (pending == $past(press))); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (pending && !take) |=> pending); // R3

endmodule

// File: rtl/xing_seq.sv
// Phase sequencer with registered lamp outputs.
module xing_seq
  import xing_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic min_end,
  input  logic pending,
  output logic take,
  output logic ns_go,
  output logic ew_go
);

  phase_e phase_q, phase_d;
  logic   last_q, last_d;
  logic   ns_q, ew_q;

  always_comb begin
    phase_d = phase_q;
    last_d  = last_q;
    take    = 1'b0;
    if (min_end) begin
      unique case (phase_q)
        PH_EW: begin
          if (pending) begin
            phase_d = PH_WALK;
            last_d  = ST_EW;
            take    = 1'b1;
          end else begin
            phase_d = PH_NS;
          end
        end
        PH_NS: begin
          if (pending) begin
            phase_d = PH_WALK;
            last_d  = ST_NS;
            take    = 1'b1;
          end else begin
            phase_d = PH_EW;
          end
        end
        PH_WALK: phase_d = street_phase(!last_q);
        default: phase_d = PH_EW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_EW;
      last_q  <= ST_EW;
      ns_q    <= 1'b0;
      ew_q    <= 1'b1;
    end else begin
      phase_q <= phase_d;
      last_q  <= last_d;
      ns_q    <= ns_lamp(phase_d);
      ew_q    <= ew_lamp(phase_d);
    end
  end

  assign ns_go = ns_q;
  assign ew_go = ew_q;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !min_end |=> $stable(phase_q)); // R2

  AST_NO_WALK_TWICE: assert property (@(posedge clk) disable iff (rst)
    (min_end && phase_q == PH_WALK) |=> (phase_q != PH_WALK)); // R7

  AST_NO_WALK_UNASKED: assert property (@(posedge clk) disable iff (rst)
    (min_end && phase_q != PH_WALK && !pending) |=> (phase_q != PH_WALK)); // R3

  AST_WALK_LAMPS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WALK) |-> (ns_go && ew_go)); // R4

endmodule

// File: rtl/xing_ctrl.sv
// Two-street crossing controller with a latched pedestrian phase.
module xing_ctrl #(
  parameter int unsigned TICKS_PER_MIN = 6000000
) (
  input  logic clk,
  input  logic rst,
  input  logic walk_btn,
  output logic ns_go,
  output logic ew_go
);

  logic min_end;
  logic pending;
  logic take;

  xing_tick #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .min_end (min_end)
  );

  xing_req u_req (
    .clk     (clk),
    .rst     (rst),
    .press   (walk_btn),
    .take    (take),
    .pending (pending)
  );

  xing_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .min_end (min_end),
    .pending (pending),
    .take    (take),
    .ns_go   (ns_go),
    .ew_go   (ew_go)
  );

  AST_NEVER_DARK: assert property (@(posedge clk) disable iff (rst)
    (ns_go || ew_go)); // R9

endmodule

// File: tb/xing_ctrl_tb.sv
module xing_ctrl_tb;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic walk_btn = 1'b0;
  logic ns_go, ew_go;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state: phase 0=EW, 1=NS, 2=walk.
  int mcnt = 0;
  int mph = 0;
  bit mreq = 1'b0;
  bit mlast = 1'b0;
  int since_walk = 1000;
  string scen_tag = "R1";

  int run_len = 0;
  bit prev_ns = 1'b0, prev_ew = 1'b1;
  bit run_valid = 1'b0;
  int walk_seen = 0;

  always #10 clk = ~clk; // 50 MHz

  xing_ctrl #(.TICKS_PER_MIN(N)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .walk_btn (walk_btn),
    .ns_go    (ns_go),
    .ew_go    (ew_go)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {ns,ew} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Model of the requirements, advanced at each rising edge.
  always @(posedge clk) begin
    bit bnd;
    bit tk;
    if (rst) begin
      mcnt = 0; mph = 0; mreq = 1'b0; mlast = 1'b0;
    end else begin
      bnd = (mcnt == N - 1);
      tk = 1'b0;
      if (bnd) begin
        mcnt = 0;
        if (mph == 2) begin
          mph = (mlast == 1'b0) ? 1 : 0;
          since_walk = 0;
        end else if (mreq) begin
          tk = 1'b1; mlast = mph[0]; mph = 2;
        end else begin
          mph = mph ^ 1;
        end
      end else begin
        mcnt++;
      end
      if (mph != 2 && since_walk < 1000) since_walk++;
      mreq = (mreq && !tk) || walk_btn;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    logic [1:0] exp;
    string tag;
    if (!rst && !done) begin
      exp = {1'(mph != 0), 1'(mph != 1)};
      if (mph == 2) tag = "R4";
      else if (since_walk <= N) tag = "R6";
      else tag = scen_tag;
      check(tag, {ns_go, ew_go}, exp);
      checks++;
      if (!(ns_go || ew_go)) begin
        errors++;
        $display("FAIL R9: {ns,ew} actual=%b expected=not 00", {ns_go, ew_go});
      end
      if (run_valid && (ns_go != prev_ns || ew_go != prev_ew)) begin
        checks++;
        if (run_len != N) begin
          errors++;
          $display("FAIL R2: phase length actual=%0d expected=%0d", run_len, N);
        end
        if (ns_go && ew_go) walk_seen++;
        run_len = 1;
      end else begin
        run_len++;
      end
      run_valid = 1'b1;
      prev_ns = ns_go;
      prev_ew = ew_go;
    end else begin
      run_valid = 1'b0;
      run_len = 0;
    end
  end

  task automatic press_once();
    walk_btn = 1'b1;
    @(negedge clk);
    walk_btn = 1'b0;
  endtask

  task automatic wait_at(input int cnt, input int ph);
    do @(negedge clk); while (!(mcnt == cnt && mph == ph));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8", {ns_go, ew_go}, 2'b01);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int w0;
    do_reset();
    check("R8", {ns_go, ew_go}, 2'b01);

    // R1: free alternation over several minutes.
    scen_tag = "R1";
    repeat (5 * N) @(negedge clk);

    // R3: single mid-phase press during EW phase; outputs unchanged next cycle.
    scen_tag = "R3";
    wait_at(2, 0);
    press_once();
    check("R3", {ns_go, ew_go}, 2'b01);
    w0 = walk_seen;
    repeat (4 * N) @(negedge clk);
    checks++;
    if (walk_seen - w0 != 1) begin
      errors++;
      $display("FAIL R3: walks actual=%0d expected=1", walk_seen - w0);
    end

    // R5: burst of presses during NS phase gives one walk.
    scen_tag = "R5";
    wait_at(0, 1);
    w0 = walk_seen;
    for (int i = 0; i < N - 2; i++) begin
      if (i % 2 == 0) walk_btn = 1'b1; else walk_btn = 1'b0;
      @(negedge clk);
    end
    walk_btn = 1'b0;
    repeat (5 * N) @(negedge clk);
    checks++;
    if (walk_seen - w0 != 1) begin
      errors++;
      $display("FAIL R5: walks actual=%0d expected=1", walk_seen - w0);
    end

    // R7: press during walk phase, then press on the boundary edge.
    scen_tag = "R7";
    wait_at(1, 0);
    press_once();
    wait_at(3, 2);
    press_once();
    repeat (6 * N) @(negedge clk);
    wait_at(N - 1, 0);
    press_once();
    repeat (5 * N) @(negedge clk);

    // R8: reset with a request pending discards it.
    scen_tag = "R8";
    wait_at(4, 1);
    press_once();
    do_reset();
    check("R8", {ns_go, ew_go}, 2'b01);
    w0 = walk_seen;
    repeat (3 * N) @(negedge clk);
    checks++;
    if (walk_seen != w0) begin
      errors++;
      $display("FAIL R8: walks actual=%0d expected=0", walk_seen - w0);
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule